// File: doc/BRIEF.md
# Event Interrupt Status and Mask Unit

This unit collects the event conditions of a serial controller's transmit and receive queues into one status register and drives a single interrupt line. Two of the events are one-cycle error pulses: receive queue overflow and transmit queue underflow. The other four are level conditions: transmit queue full, receive queue not empty, receive queue full, and transmit queue below its programmed watermark. Software clears status bits by writing ones to them.

Which events may raise the interrupt is held in a mask register. Software never writes the mask directly. A write through the enable select sets mask bits, a write through the disable select clears them, and the current mask is read through its own read-only select. The status, enable, disable and mask registers all share one bit layout.

The register port has no state machine. A 2-bit select (`reg_sel_e`) names the register. A write strobe acts on that register at the next clock edge. The read data is a combinational view of the selected register.

Top module: `evt_irq_unit`

## Requirements
- R1: After reset, the status register and the mask register both read 0x00, and `irq` is low.
- R2: The select encoding is 0 = status, 1 = enable, 2 = disable, 3 = mask. A one-cycle `rx_ovf_evt` pulse sets status bit 0, and a one-cycle `tx_unf_evt` pulse sets status bit 6. Each of these bits stays 1 after its pulse ends, until software clears it.
- R3: Status bit 2 is set in every cycle where `tx_count < tx_wmark`, with both compared as unsigned values. Bits 3, 4 and 5 are set in every cycle where `tx_full_lvl`, `rx_nempty_lvl` and `rx_full_lvl` are high, respectively. Each bit becomes visible after the clock edge that samples its condition.
- R4: A write to select 0 clears every status bit written as 1 and leaves bits written as 0 unchanged. If a bit's source is active in the same cycle as the clear, that bit stays 1.
- R5: A write to select 1 sets the mask bits written as 1. A write to select 2 clears the mask bits written as 1. Bits written as 0 are unchanged in both cases.
- R6: Selects 1 and 2 always read back 0x00. Select 3 reads back the current mask.
- R7: `irq` is high exactly when some status bit and the matching mask bit are both 1.
- R8: Bits 1 and 7 read as 0 in both the status and mask registers, whatever is written to them.
- R9: When `reg_wr` is low, `reg_wdata` has no effect on status or mask. A status write leaves the mask unchanged, and a mask write leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select (0 status, 1 enable, 2 disable, 3 mask) |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| rx_ovf_evt | input | 1 | Receive queue overflow pulse |
| tx_unf_evt | input | 1 | Transmit queue underflow pulse |
| tx_full_lvl | input | 1 | Transmit queue full level |
| rx_nempty_lvl | input | 1 | Receive queue not-empty level |
| rx_full_lvl | input | 1 | Receive queue full level |
| tx_count | input | CNT_W (7) | Transmit queue occupancy |
| tx_wmark | input | CNT_W (7) | Transmit watermark |
| irq | output | 1 | Interrupt request |

## Verification
A status clear and a new event on the same bit can arrive in the same cycle. In that case the event must win. The bench provokes this in two ways. It pulses the overflow input in the same cycle as a write-one-to-clear of bit 0. It also clears the not-empty bit while the not-empty level is held high. In both cases it expects the bit to read 1 afterwards, and `irq` to stay high when the bit is enabled.

A mask write can also coincide with a new event. The bench pulses underflow during a disable write to a different bit, and checks that both effects land.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int EVW = 8;

    localparam int IDX_RX_OVF  = 0;
    localparam int IDX_TX_LOW  = 2;
    localparam int IDX_TX_FULL = 3;
    localparam int IDX_RX_NE   = 4;
    localparam int IDX_RX_FULL = 5;
    localparam int IDX_TX_UNF  = 6;

    // Bits that hold state; bits 1 and 7 are reserved and read as zero.
    localparam logic [EVW-1:0] IMPL_MASK = (EVW'(1) << IDX_RX_OVF)  |
                                           (EVW'(1) << IDX_TX_LOW)  |
                                           (EVW'(1) << IDX_TX_FULL) |
                                           (EVW'(1) << IDX_RX_NE)   |
                                           (EVW'(1) << IDX_RX_FULL) |
                                           (EVW'(1) << IDX_TX_UNF);

    typedef enum logic [1:0] {
        SEL_STATUS  = 2'd0,
        SEL_ENABLE  = 2'd1,
        SEL_DISABLE = 2'd2,
        SEL_MASK    = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/evt_src_collect.sv
module evt_src_collect
    import evt_irq_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             rx_ovf_evt,
    input  logic             tx_unf_evt,
    input  logic             tx_full_lvl,
    input  logic             rx_nempty_lvl,
    input  logic             rx_full_lvl,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] tx_wmark,
    output logic [EVW-1:0]   set_vec
);

    logic tx_below;

    always_comb begin
        tx_below = (tx_count < tx_wmark);
        set_vec  = '0;
        set_vec[IDX_RX_OVF]  = rx_ovf_evt;
        set_vec[IDX_TX_LOW]  = tx_below;
        set_vec[IDX_TX_FULL] = tx_full_lvl;
        set_vec[IDX_RX_NE]   = rx_nempty_lvl;
        set_vec[IDX_RX_FULL] = rx_full_lvl;
        set_vec[IDX_TX_UNF]  = tx_unf_evt;
    end

endmodule

// File: rtl/evt_status_bank.sv
module evt_status_bank
    import evt_irq_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [EVW-1:0] set_vec,
    input  logic [EVW-1:0] clr_vec,
    output logic [EVW-1:0] status
);

    for (genvar k = 0; k < EVW; k++) begin : g_bit
        if (IMPL_MASK[k]) begin : g_impl
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else begin
                    // A source active in the same cycle overrides the clear.
                    bit_q <= (bit_q & ~clr_vec[k]) | set_vec[k];
                end
            end
            assign status[k] = bit_q;

            assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
                set_vec[k] |=> status[k]);
            assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_vec[k] && !set_vec[k]) |=> !status[k]);
            assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (status[k] && !clr_vec[k]) |=> status[k]);
        end else begin : g_rsvd
            assign status[k] = 1'b0;
        end
    end

endmodule

// File: rtl/evt_mask_bank.sv
module evt_mask_bank
    import evt_irq_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [EVW-1:0] en_vec,
    input  logic [EVW-1:0] dis_vec,
    output logic [EVW-1:0] mask
);

    for (genvar k = 0; k < EVW; k++) begin : g_bit
        if (IMPL_MASK[k]) begin : g_impl
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else if (en_vec[k]) begin
                    bit_q <= 1'b1;
                end else if (dis_vec[k]) begin
                    bit_q <= 1'b0;
                end
            end
            assign mask[k] = bit_q;

            assert_mask_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
                en_vec[k] |=> mask[k]);
            assert_mask_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (dis_vec[k] && !en_vec[k]) |=> !mask[k]);
            assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (!en_vec[k] && !dis_vec[k]) |=> $stable(mask[k]));
        end else begin : g_rsvd
            assign mask[k] = 1'b0;
        end
    end

endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
    import evt_irq_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_sel,
    input  logic             reg_wr,
    input  logic [EVW-1:0]   reg_wdata,
    output logic [EVW-1:0]   reg_rdata,
    input  logic             rx_ovf_evt,
    input  logic             tx_unf_evt,
    input  logic             tx_full_lvl,
    input  logic             rx_nempty_lvl,
    input  logic             rx_full_lvl,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] tx_wmark,
    output logic             irq
);

    reg_sel_e       sel;
    logic [EVW-1:0] wdata_impl;
    logic [EVW-1:0] set_vec;
    logic [EVW-1:0] clr_vec;
    logic [EVW-1:0] en_vec;
    logic [EVW-1:0] dis_vec;
    logic [EVW-1:0] status;
    logic [EVW-1:0] mask;

    assign sel        = reg_sel_e'(reg_sel);
    assign wdata_impl = reg_wdata & IMPL_MASK;

    // Route a write strobe to exactly one of the three writable views.
    always_comb begin
        clr_vec = '0;
        en_vec  = '0;
        dis_vec = '0;
        if (reg_wr) begin
            unique case (sel)
                SEL_STATUS:  clr_vec = wdata_impl;
                SEL_ENABLE:  en_vec  = wdata_impl;
                SEL_DISABLE: dis_vec = wdata_impl;
                SEL_MASK:    ;
                default:     ;
            endcase
        end
    end

    evt_src_collect #(.CNT_W(CNT_W)) u_src (
        .rx_ovf_evt    (rx_ovf_evt),
        .tx_unf_evt    (tx_unf_evt),
        .tx_full_lvl   (tx_full_lvl),
        .rx_nempty_lvl (rx_nempty_lvl),
        .rx_full_lvl   (rx_full_lvl),
        .tx_count      (tx_count),
        .tx_wmark      (tx_wmark),
        .set_vec       (set_vec)
    );

    evt_status_bank u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .status  (status)
    );

    evt_mask_bank u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_vec  (en_vec),
        .dis_vec (dis_vec),
        .mask    (mask)
    );

    // Read view: enable and disable are write-only.
    always_comb begin
        unique case (sel)
            SEL_STATUS:  reg_rdata = status;
            SEL_MASK:    reg_rdata = mask;
            default:     reg_rdata = '0;
        endcase
    end

    assign irq = |(status & mask);

    assert_wo_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_ENABLE || reg_sel == SEL_DISABLE) |-> (reg_rdata == '0));
    assert_rsvd_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~IMPL_MASK) == '0);
    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
    assert_nowr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && set_vec == '0) |=> $stable(status));

endmodule

// File: tb/evt_irq_unit_tb_top.sv
module evt_irq_unit_tb_top;

    localparam int CNT_W = 7;
    localparam int NVEC  = 18;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       reg_sel = 2'd0;
    logic             reg_wr = 1'b0;
    logic [7:0]       reg_wdata = 8'h00;
    logic [7:0]       reg_rdata;
    logic             rx_ovf_evt = 1'b0;
    logic             tx_unf_evt = 1'b0;
    logic             tx_full_lvl = 1'b0;
    logic             rx_nempty_lvl = 1'b0;
    logic             rx_full_lvl = 1'b0;
    logic [CNT_W-1:0] tx_count = '0;
    logic [CNT_W-1:0] tx_wmark = '0;
    logic             irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    evt_irq_unit #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_ovf_evt(rx_ovf_evt), .tx_unf_evt(tx_unf_evt),
        .tx_full_lvl(tx_full_lvl), .rx_nempty_lvl(rx_nempty_lvl),
        .rx_full_lvl(rx_full_lvl), .tx_count(tx_count), .tx_wmark(tx_wmark),
        .irq(irq)
    );

    // Row: we, sel, wdata, {ovf,unf,txf,rxne,rxf}, tx_count, tx_wmark, exp_status, exp_mask, exp_irq
    localparam logic [46:0] VEC [0:NVEC-1] = '{
        {1'b0, 2'd0, 8'h00, 5'b10000, 7'd0, 7'd0, 8'h01, 8'h00, 1'b0}, // R2 overflow
        {1'b1, 2'd1, 8'h01, 5'b00000, 7'd0, 7'd0, 8'h01, 8'h01, 1'b1}, // R5 R7 R2
        {1'b1, 2'd0, 8'h01, 5'b00000, 7'd0, 7'd0, 8'h00, 8'h01, 1'b0}, // R4
        {1'b0, 2'd0, 8'h00, 5'b00010, 7'd0, 7'd0, 8'h10, 8'h01, 1'b0}, // R3 not empty
        {1'b1, 2'd1, 8'h10, 5'b00010, 7'd0, 7'd0, 8'h10, 8'h11, 1'b1}, // R5 R7
        {1'b1, 2'd0, 8'h10, 5'b00010, 7'd0, 7'd0, 8'h10, 8'h11, 1'b1}, // R4 clear vs live
        {1'b1, 2'd0, 8'h10, 5'b00000, 7'd0, 7'd0, 8'h00, 8'h11, 1'b0}, // R4
        {1'b0, 2'd0, 8'h00, 5'b00000, 7'd3, 7'd5, 8'h04, 8'h11, 1'b0}, // R3 below watermark
        {1'b1, 2'd0, 8'h04, 5'b00000, 7'd5, 7'd5, 8'h00, 8'h11, 1'b0}, // R3 equal not below
        {1'b1, 2'd1, 8'h04, 5'b00000, 7'd5, 7'd6, 8'h04, 8'h15, 1'b1}, // R3 R5
        {1'b1, 2'd2, 8'h15, 5'b00000, 7'd5, 7'd6, 8'h04, 8'h00, 1'b0}, // R5 disable R9
        {1'b0, 2'd0, 8'h00, 5'b01101, 7'd5, 7'd6, 8'h6C, 8'h00, 1'b0}, // R2 R3 multi
        {1'b1, 2'd1, 8'hFF, 5'b00000, 7'd0, 7'd0, 8'h6C, 8'h7D, 1'b1}, // R8 R5
        {1'b1, 2'd0, 8'hFF, 5'b00000, 7'd0, 7'd0, 8'h00, 8'h7D, 1'b0}, // R4 R8
        {1'b1, 2'd0, 8'h01, 5'b10000, 7'd0, 7'd0, 8'h01, 8'h7D, 1'b1}, // R4 event wins
        {1'b0, 2'd0, 8'hFF, 5'b00000, 7'd0, 7'd0, 8'h01, 8'h7D, 1'b1}, // R9 no write
        {1'b1, 2'd2, 8'h01, 5'b01000, 7'd0, 7'd0, 8'h41, 8'h7C, 1'b1}, // R5 R2 same cycle
        {1'b1, 2'd0, 8'h40, 5'b00000, 7'd0, 7'd0, 8'h01, 8'h7C, 1'b0}  // R4 R7
    };

    task automatic check8(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", what, act, exp);
        end
    endtask

    task automatic read_check(input logic [1:0] sel, input string what, input logic [7:0] exp);
        reg_sel = sel;
        #1;
        check8(what, reg_rdata, exp);
    endtask

    task automatic idle_inputs();
        reg_wr = 1'b0; reg_wdata = 8'h00; rx_ovf_evt = 1'b0; tx_unf_evt = 1'b0;
        tx_full_lvl = 1'b0; rx_nempty_lvl = 1'b0; rx_full_lvl = 1'b0;
        tx_count = '0; tx_wmark = '0;
    endtask

    initial begin : watchdog
        #400000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        idle_inputs();
        repeat (3) @(negedge clk);
        // R1 reset state while held in reset and after release
        read_check(2'd0, "R1 status in reset", 8'h00);
        read_check(2'd3, "R1 mask in reset", 8'h00);
        check8("R1 irq in reset", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        read_check(2'd0, "R1 status after reset", 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            reg_wr        = VEC[i][46];
            reg_sel       = VEC[i][45:44];
            reg_wdata     = VEC[i][43:36];
            rx_ovf_evt    = VEC[i][35];
            tx_unf_evt    = VEC[i][34];
            tx_full_lvl   = VEC[i][33];
            rx_nempty_lvl = VEC[i][32];
            rx_full_lvl   = VEC[i][31];
            tx_count      = VEC[i][30:24];
            tx_wmark      = VEC[i][23:17];
            @(posedge clk);
            #1;
            reg_wr = 1'b0; rx_ovf_evt = 1'b0; tx_unf_evt = 1'b0;
            read_check(2'd0, $sformatf("vec %0d status R2 R3 R4 R8 R9", i), VEC[i][16:9]);
            read_check(2'd3, $sformatf("vec %0d mask R5 R8 R9", i), VEC[i][8:1]);
            check8($sformatf("vec %0d irq R7", i), {7'd0, irq}, {7'd0, VEC[i][0]});
        end

        // R6 write-only selects read as zero while mask is nonzero
        @(negedge clk);
        idle_inputs();
        read_check(2'd1, "R6 enable readback", 8'h00);
        read_check(2'd2, "R6 disable readback", 8'h00);
        read_check(2'd3, "R6 mask readback", 8'h7C);

        // R9 writing mask select (read-only) changes nothing
        @(negedge clk);
        reg_sel = 2'd3; reg_wr = 1'b1; reg_wdata = 8'hFF;
        @(posedge clk); #1; reg_wr = 1'b0;
        read_check(2'd3, "R9 mask after write to read-only", 8'h7C);
        read_check(2'd0, "R9 status after write to read-only", 8'h01);

        // R1 reset in mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        read_check(2'd0, "R1 status after mid reset", 8'h00);
        read_check(2'd3, "R1 mask after mid reset", 8'h00);
        check8("R1 irq after mid reset", {7'd0, irq}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule